// File: doc/BRIEF.md
# Indirect Register Window

This block is the bus-facing front end of an interrupt routing controller. Software cannot address the controller's registers directly. It first writes a register index into a select location. It then reads or writes a single 32-bit data window, and that access is steered to whichever register the latched index names. Two kinds of register live here: an identification register and a read-only version register. The third kind, the 64-bit routing entries, is held by the neighbouring service engine. This block reaches those entries through a write strobe, a half-select, an entry number and a data word.

Each 64-bit routing entry takes up two consecutive indices, starting at a fixed table base. The even index of the pair reaches the low 32 bits and the odd index reaches the high 32 bits. The version register reports how many entries exist by giving the highest valid entry number, which is derived from the pin-count parameter. Bus accesses are single-cycle strobes. Read data is registered and appears one cycle after the read strobe.

Top module: `ioreg_window`

## Requirements
- R1: A write to offset 0x00 latches `bus_wdata[7:0]` as the register index. A read of offset 0x00 returns that index zero-extended to 32 bits.
- R2: At index 0x00 the window stores only `bus_wdata[27:24]` as the ID. It reads back with the ID in bits [27:24] and zeros elsewhere, and the ID is also driven on `apic_id`.
- R3: At index 0x01 the window reads `0x11` in bits [7:0], NUM_PINS-1 in bits [23:16], and zero in all other bits. Writes to this index change nothing.
- R4: For an index of 0x10 or above, the entry number is (index-0x10)>>1. If that number is NUM_PINS or more, a write raises no `tbl_we` and a read returns zero.
- R5: An odd table index selects entry bits [63:32] and an even index selects bits [31:0]. A window write raises `tbl_we` for exactly the strobe cycle, together with `tbl_hi`, `tbl_idx` and `tbl_wdata` equal to the bus data, so that only the addressed half changes.
- R6: Indices 0x02 to 0x0F and every bus offset other than 0x00 and 0x10 read as zero. Writes to them change no state.
- R7: `bus_rdata` is loaded on the clock edge that samples `bus_rd` and holds its value when no read is strobed. For a table read, `tbl_rentry` must present the entry named by `tbl_idx` in the same cycle.
- R8: After synchronous reset the index, the ID and `bus_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 8 | Byte offset, low 8 bits of the address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| apic_id | output | 4 | Stored controller ID |
| tbl_we | output | 1 | Routing-table half write strobe |
| tbl_hi | output | 1 | 1 selects entry bits [63:32] |
| tbl_idx | output | 5 | Entry number selected by the index |
| tbl_wdata | output | 32 | Data for the addressed half |
| tbl_rentry | input | 64 | Entry contents at `tbl_idx` from the service engine |

## Verification
The assertions check several rules on every cycle. `tbl_we` appears only during a write to the window offset, with an in-range entry, with the data passed through unchanged, and with the half chosen by the index parity. The index and the ID move only on writes to their own locations. Read data stays still when no read is strobed. The bench scenarios are needed for everything else. They show the exact decoded values: ID masking, the version word, the split of entries into halves against a model of the engine's table, and zero reads from undefined indices and offsets, including that writes to those places leave every readable value unchanged.

// File: rtl/ioreg_pkg.sv
// Shared types for the indirect register window.
package ioreg_pkg;
    // Class of register that a latched index resolves to.
    typedef enum logic [1:0] {
        REG_ID    = 2'd0,
        REG_VER   = 2'd1,
        REG_ENTRY = 2'd2,
        REG_NONE  = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/ioreg_offset_dec.sv
// Bus offset decoder.
// Compares the low address byte against the select and window offsets.
// Assumes the two offsets are different.
module ioreg_offset_dec #(
    parameter int unsigned         ADDR_W  = 8,
    parameter logic [ADDR_W-1:0]   SEL_OFF = 8'h00,
    parameter logic [ADDR_W-1:0]   WIN_OFF = 8'h10
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_sel,
    output logic              hit_win
);
    // Purpose: flag which of the two defined locations is addressed.
    always_comb begin
        hit_sel = (addr == SEL_OFF);
        hit_win = (addr == WIN_OFF);
    end
endmodule

// File: rtl/ioreg_index_dec.sv
// Register index decoder.
// Maps a latched index onto a register class, an entry number and a half.
// Assumes TBL_BASE is even and above the version index.
module ioreg_index_dec
    import ioreg_pkg::*;
#(
    parameter int unsigned        IDX_W    = 8,
    parameter int unsigned        NUM_PINS = 24,
    parameter int unsigned        ENT_W    = 5,
    parameter logic [IDX_W-1:0]   TBL_BASE = 8'h10
) (
    input  logic [IDX_W-1:0] idx,
    output reg_kind_e        kind,
    output logic [ENT_W-1:0] entry,
    output logic             upper
);
    localparam logic [IDX_W-2:0] PIN_LIMIT = (IDX_W-1)'(NUM_PINS);

    logic [IDX_W-1:0] rel;
    logic [IDX_W-2:0] ent_full;
    logic             in_table;

    // Purpose: compute the offset from the table base and its entry number.
    always_comb begin
        rel      = idx - TBL_BASE;
        ent_full = rel[IDX_W-1:1];
        in_table = (idx >= TBL_BASE) && (ent_full < PIN_LIMIT);
    end

    // Purpose: classify the index and pick the half of the entry.
    always_comb begin
        entry = in_table ? ent_full[ENT_W-1:0] : '0;
        upper = rel[0];
        if (idx == '0)
            kind = REG_ID;
        else if (idx == IDX_W'(1))
            kind = REG_VER;
        else if (in_table)
            kind = REG_ENTRY;
        else
            kind = REG_NONE;
    end
endmodule

// File: rtl/ioreg_read_mux.sv
// Read data selector.
// Builds the next read word from the addressed location.
// Assumes tbl_rentry already reflects the entry at the decoded entry number.
module ioreg_read_mux
    import ioreg_pkg::*;
#(
    parameter int unsigned      DATA_W   = 32,
    parameter int unsigned      IDX_W    = 8,
    parameter int unsigned      ID_W     = 4,
    parameter int unsigned      ID_LSB   = 24,
    parameter int unsigned      NUM_PINS = 24,
    parameter logic [7:0]       VERSION  = 8'h11
) (
    input  logic                hit_sel,
    input  logic                hit_win,
    input  reg_kind_e           kind,
    input  logic                upper,
    input  logic [IDX_W-1:0]    sel_idx,
    input  logic [ID_W-1:0]     id_val,
    input  logic [2*DATA_W-1:0] tbl_rentry,
    output logic [DATA_W-1:0]   rd_word
);
    localparam logic [7:0]        MAX_ENT  = 8'(NUM_PINS - 1);
    localparam logic [DATA_W-1:0] VER_WORD = DATA_W'({8'h00, MAX_ENT, 8'h00, VERSION});

    logic [DATA_W-1:0] win_word;

    // Purpose: pick the window value for the latched register class.
    always_comb begin
        unique case (kind)
            REG_ID:    win_word = DATA_W'(id_val) << ID_LSB;
            REG_VER:   win_word = VER_WORD;
            REG_ENTRY: win_word = upper ? tbl_rentry[2*DATA_W-1:DATA_W]
                                        : tbl_rentry[DATA_W-1:0];
            default:   win_word = '0;
        endcase
    end

    // Purpose: choose between select readback, window data and zero.
    always_comb begin
        if (hit_sel)
            rd_word = DATA_W'(sel_idx);
        else if (hit_win)
            rd_word = win_word;
        else
            rd_word = '0;
    end
endmodule

// File: rtl/ioreg_window.sv
// Indirect register window top.
// Holds the select index, the ID and the registered read data. Forwards
// window writes aimed at routing entries to the service engine's table.
// Assumes single-cycle bus strobes and a combinational table read port.
module ioreg_window
    import ioreg_pkg::*;
#(
    parameter int unsigned      ADDR_W   = 8,
    parameter int unsigned      DATA_W   = 32,
    parameter int unsigned      IDX_W    = 8,
    parameter int unsigned      NUM_PINS = 24,
    parameter int unsigned      ID_W     = 4,
    parameter int unsigned      ID_LSB   = 24,
    parameter logic [ADDR_W-1:0] SEL_OFF = 8'h00,
    parameter logic [ADDR_W-1:0] WIN_OFF = 8'h10,
    parameter logic [IDX_W-1:0] TBL_BASE = 8'h10,
    parameter logic [7:0]       VERSION  = 8'h11,
    localparam int unsigned     ENT_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [ID_W-1:0]     apic_id,
    output logic                tbl_we,
    output logic                tbl_hi,
    output logic [ENT_W-1:0]    tbl_idx,
    output logic [DATA_W-1:0]   tbl_wdata,
    input  logic [2*DATA_W-1:0] tbl_rentry
);
    logic [IDX_W-1:0]  sel_q;
    logic              hit_sel;
    logic              hit_win;
    reg_kind_e         kind;
    logic              upper;
    logic [DATA_W-1:0] rd_word;

    ioreg_offset_dec #(
        .ADDR_W (ADDR_W),
        .SEL_OFF(SEL_OFF),
        .WIN_OFF(WIN_OFF)
    ) u_offset_dec (
        .addr   (bus_addr),
        .hit_sel(hit_sel),
        .hit_win(hit_win)
    );

    ioreg_index_dec #(
        .IDX_W   (IDX_W),
        .NUM_PINS(NUM_PINS),
        .ENT_W   (ENT_W),
        .TBL_BASE(TBL_BASE)
    ) u_index_dec (
        .idx  (sel_q),
        .kind (kind),
        .entry(tbl_idx),
        .upper(upper)
    );

    ioreg_read_mux #(
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W),
        .ID_W    (ID_W),
        .ID_LSB  (ID_LSB),
        .NUM_PINS(NUM_PINS),
        .VERSION (VERSION)
    ) u_read_mux (
        .hit_sel   (hit_sel),
        .hit_win   (hit_win),
        .kind      (kind),
        .upper     (upper),
        .sel_idx   (sel_q),
        .id_val    (apic_id),
        .tbl_rentry(tbl_rentry),
        .rd_word   (rd_word)
    );

    // Purpose: latch the register index on a select write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (bus_wr && hit_sel)
            sel_q <= bus_wdata[IDX_W-1:0];
    end

    // Purpose: store the ID field on a window write to the ID index.
    always_ff @(posedge clk) begin
        if (!rst_n)
            apic_id <= '0;
        else if (bus_wr && hit_win && kind == REG_ID)
            apic_id <= bus_wdata[ID_LSB +: ID_W];
    end

    // Purpose: register read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_word;
    end

    // Purpose: forward window writes for valid entries to the table.
    always_comb begin
        tbl_we    = bus_wr && hit_win && (kind == REG_ENTRY);
        tbl_hi    = upper;
        tbl_wdata = bus_wdata;
    end
endmodule

// File: rtl/ioreg_window_chk.sv
// Checker for the indirect register window, attached to the top by bind.
// Assumes it sees the latched select index through the bind connection.
module ioreg_window_chk #(
    parameter int unsigned       ADDR_W   = 8,
    parameter int unsigned       DATA_W   = 32,
    parameter int unsigned       IDX_W    = 8,
    parameter int unsigned       NUM_PINS = 24,
    parameter int unsigned       ID_W     = 4,
    parameter int unsigned       ENT_W    = 5,
    parameter logic [ADDR_W-1:0] SEL_OFF  = 8'h00,
    parameter logic [ADDR_W-1:0] WIN_OFF  = 8'h10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [ID_W-1:0]   apic_id,
    input logic              tbl_we,
    input logic              tbl_hi,
    input logic [ENT_W-1:0]  tbl_idx,
    input logic [DATA_W-1:0] tbl_wdata,
    input logic [IDX_W-1:0]  sel_q
);
    // Table strobe only during a window write (R5, R6).
    assert_tbl_we_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> (bus_wr && bus_addr == WIN_OFF));

    // Table strobe only for an existing entry (R4).
    assert_tbl_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> (32'(tbl_idx) < NUM_PINS));

    // Half follows index parity and data passes through (R5).
    assert_tbl_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> (tbl_hi == sel_q[0] && tbl_wdata == bus_wdata));

    // Select latches the low byte of a select write (R1).
    assert_sel_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_OFF) |=> (sel_q == $past(bus_wdata[IDX_W-1:0])));

    // Select holds without a select write (R1, R6).
    assert_sel_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == SEL_OFF) |=> $stable(sel_q));

    // ID changes only on a window write (R2).
    assert_id_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == WIN_OFF) |=> $stable(apic_id));

    // Read data holds when no read is strobed (R7).
    assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind ioreg_window ioreg_window_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W),
    .NUM_PINS(NUM_PINS),
    .ID_W    (ID_W),
    .ENT_W   (ENT_W),
    .SEL_OFF (SEL_OFF),
    .WIN_OFF (WIN_OFF)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .apic_id  (apic_id),
    .tbl_we   (tbl_we),
    .tbl_hi   (tbl_hi),
    .tbl_idx  (tbl_idx),
    .tbl_wdata(tbl_wdata),
    .sel_q    (sel_q)
);

// File: tb/ioreg_window_tb.sv
`timescale 1ns/1ps
module ioreg_window_tb;
    localparam int unsigned NUM_PINS = 24;
    localparam logic [7:0]  SEL      = 8'h00;
    localparam logic [7:0]  WIN      = 8'h10;

    typedef struct packed {
        logic [7:0]  idx;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    // Window vectors: index, written value, expected readback.
    localparam vec_t VECS [10] = '{
        '{8'h00, 32'hFFFF_FFFF, 32'h0F00_0000},   // R2 mask
        '{8'h00, 32'h0A12_3456, 32'h0A00_0000},   // R2
        '{8'h01, 32'hDEAD_BEEF, 32'h0017_0011},   // R3 read-only
        '{8'h10, 32'h1234_5678, 32'h1234_5678},   // R5 entry 0 low
        '{8'h11, 32'h9ABC_DEF0, 32'h9ABC_DEF0},   // R5 entry 0 high
        '{8'h3E, 32'h0BAD_F00D, 32'h0BAD_F00D},   // R4 last entry low
        '{8'h3F, 32'hCAFE_F00D, 32'hCAFE_F00D},   // R4 last entry high
        '{8'h40, 32'h5555_5555, 32'h0000_0000},   // R4 out of range
        '{8'h05, 32'h7777_7777, 32'h0000_0000},   // R6 undefined index
        '{8'hFF, 32'h3333_3333, 32'h0000_0000}    // R4 top index
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  apic_id;
    logic        tbl_we;
    logic        tbl_hi;
    logic [4:0]  tbl_idx;
    logic [31:0] tbl_wdata;
    logic [63:0] tbl_rentry;
    logic [63:0] tbl_mem [NUM_PINS];

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    ioreg_window u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .apic_id   (apic_id),
        .tbl_we    (tbl_we),
        .tbl_hi    (tbl_hi),
        .tbl_idx   (tbl_idx),
        .tbl_wdata (tbl_wdata),
        .tbl_rentry(tbl_rentry)
    );

    // Model of the service engine's routing table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PINS; i++) tbl_mem[i] <= '0;
        end else if (tbl_we) begin
            if (tbl_hi) tbl_mem[tbl_idx][63:32] <= tbl_wdata;
            else        tbl_mem[tbl_idx][31:0]  <= tbl_wdata;
        end
    end
    assign tbl_rentry = (32'(tbl_idx) < NUM_PINS) ? tbl_mem[tbl_idx] : 64'h0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state.
        check("R8 rdata after reset", bus_rdata, 32'h0);
        check("R8 id after reset", 32'(apic_id), 32'h0);
        bus_read(SEL, rd);
        check("R8 select after reset", rd, 32'h0);
        bus_read(WIN, rd);
        check("R8 ID register after reset", rd, 32'h0);

        // Table-driven window accesses.
        for (int i = 0; i < 10; i++) begin
            bus_write(SEL, 32'(VECS[i].idx));
            bus_read(SEL, rd);
            check("R1 select readback", rd, 32'(VECS[i].idx));
            bus_write(WIN, VECS[i].wdata);
            bus_read(WIN, rd);
            check("R2-R6 window vector", rd, VECS[i].exp);
        end

        // R2: ID output port reflects stored field.
        check("R2 apic_id port", 32'(apic_id), 32'hA);

        // R5: writing the high half left the low half of entry 0 intact.
        bus_write(SEL, 32'h10);
        bus_read(WIN, rd);
        check("R5 low half kept", rd, 32'h1234_5678);
        bus_write(SEL, 32'h11);
        bus_read(WIN, rd);
        check("R5 high half kept", rd, 32'h9ABC_DEF0);

        // R5: strobe contents during an odd-index write of entry 3.
        bus_write(SEL, 32'h17);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = WIN; bus_wdata = 32'h4444_0001;
        #1;
        check("R5 tbl_we raised", 32'(tbl_we), 32'h1);
        check("R5 tbl_hi odd", 32'(tbl_hi), 32'h1);
        check("R5 tbl_idx", 32'(tbl_idx), 32'h3);
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        check("R5 tbl_we one cycle", 32'(tbl_we), 32'h0);

        // R4: out-of-range write raises no strobe.
        bus_write(SEL, 32'h40);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = WIN; bus_wdata = 32'hFFFF_FFFF;
        #1;
        check("R4 no strobe out of range", 32'(tbl_we), 32'h0);
        @(negedge clk);
        bus_wr = 1'b0;

        // R6: undefined offset reads zero, write there leaves select intact.
        bus_write(8'h20, 32'h0000_0000);
        bus_read(SEL, rd);
        check("R6 select kept after stray write", rd, 32'h40);
        bus_read(8'h20, rd);
        check("R6 undefined offset reads zero", rd, 32'h0);
        bus_read(8'h04, rd);
        check("R6 offset 0x04 reads zero", rd, 32'h0);

        // R6: write to undefined index left the ID intact.
        check("R6 id kept", 32'(apic_id), 32'hA);

        // R7: rdata holds without a read strobe.
        bus_read(SEL, rd);
        bus_write(SEL, 32'h01);
        @(negedge clk);
        check("R7 rdata held", bus_rdata, 32'h40);

        // R3: version again after writes.
        bus_read(WIN, rd);
        check("R3 version word", rd, 32'h0017_0011);

        finish_run();
    end
endmodule